// File: doc/BRIEF.md
# Multiplexed Bus Register Target

This block is a target device on a synchronous 32-bit bus where address and data share the same wires. Every transaction opens with one address cycle. In that cycle the shared lines carry an address and the four command/enable lines carry a command. One or more data cycles follow, and in each of them the same lines carry a data word and active-low byte enables. The target looks at three address spaces: a memory window, an I/O window and a small configuration space. The configuration space is reached only while the device-select input is high. When the target recognises its own address it asserts its claim signal and takes part in the transfer. Otherwise it stays silent until the bus goes idle.

Behind the decoder sits a bank of 32-bit registers. There are 16 memory words, 4 I/O words and 8 configuration dwords, and the first configuration dword is a fixed identifier. Both single and burst transfers are supported. A data word moves only on a clock edge where the initiator-ready and target-ready strobes are both low. Reads add one turnaround cycle before the target drives the data lines. Writes update only the bytes whose enable is low. The initiator marks the last data cycle by raising its frame strobe while holding initiator-ready low. After that cycle the target releases its strobes.

Top module: `busreg_target`

## Requirements
- R1: While reset is active and after it ends, devsel_n and trdy_n are high and ad_oe is low. Every register word reads zero except configuration dword 0.
- R2: Only six command codes on cbe_n are claimed: 0010 I/O read, 0011 I/O write, 0110 memory read, 0111 memory write, 1010 configuration read, 1011 configuration write. A claimed transaction has devsel_n low in the cycle after the address-cycle edge. Any other code never pulls devsel_n low.
- R3: A memory command hits when ad_in[31:6] equals MEM_BASE[31:6], and the word index is ad_in[5:2]. An I/O command hits when ad_in[31:4] equals IO_BASE[31:4], and the word index is ad_in[3:2]. The two windows are decoded independently.
- R4: A configuration command is claimed only when idsel is high, ad_in[1:0] is 00 and ad_in[7:5] is 000. The dword index is ad_in[4:2].
- R5: For a read, the cycle after the address cycle has devsel_n low, trdy_n high and ad_oe low. From the next cycle on, trdy_n is low and ad_out carries the addressed word with ad_oe high.
- R6: For a write, trdy_n is low in the cycle right after the address cycle. A word is stored on each edge where irdy_n and trdy_n are both low.
- R7: A cycle with irdy_n high inside a data phase moves no data and does not advance the word address.
- R8: Each completed data cycle advances the address by 4 bytes. The address wraps to word 0 at the end of its own window (16, 4 or 8 words).
- R9: On writes, cbe_n[k] low enables byte k (ad_in[8k+7:8k]). A write with cbe_n = 1111 changes nothing. Reads return all four bytes.
- R10: If an edge sees irdy_n low, trdy_n low and frame_n high, then after that edge devsel_n and trdy_n are high and ad_oe is low.
- R11: Configuration dword 0 always reads DEV_ID, and writes to it are discarded.
- R12: After an unclaimed address cycle, the target keeps devsel_n and trdy_n high until an edge sees both frame_n and irdy_n high. It then decodes the next address cycle normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_n | input | 1 | Initiator transaction strobe, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Device select for configuration accesses, active high |
| cbe_n | input | 4 | Command in the address cycle, active-low byte enables afterwards |
| ad_in | input | 32 | Address/data lines as seen by the target |
| devsel_n | output | 1 | Target claim, active low |
| trdy_n | output | 1 | Target ready, active low |
| ad_out | output | 32 | Read data, zero when not driving |
| ad_oe | output | 1 | High when the target drives the data lines |

## Verification
The bench stalls a read burst with irdy_n high. A design that advanced the address during the stall would hand back the wrong word. It starts bursts near the end of the memory and I/O windows, so an address counter that runs past the window without wrapping shows up as a wrong word. It checks the turnaround cycle and the release after the last data cycle directly on the strobes, and it sends partial and empty byte-enable masks. It also sends accesses that alias into the register bank through decode bits that must be compared but are easy to drop: the bit above the memory window, ad_in[7:5] and ad_in[1:0] for configuration, wrong command codes, and configuration with idsel low. It then reads the aliased word back unchanged.

// File: rtl/busreg_pkg.sv
package busreg_pkg;

  localparam int BUS_W = 32;
  localparam int LANES = BUS_W / 8;

  typedef enum logic [1:0] {
    SP_MEM = 2'd0,
    SP_IO  = 2'd1,
    SP_CFG = 2'd2
  } space_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TURN = 2'd1,
    ST_DATA = 2'd2,
    ST_SKIP = 2'd3
  } tstate_e;

  localparam logic [3:0] CMD_IO_RD  = 4'b0010;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_CFG_RD = 4'b1010;
  localparam logic [3:0] CMD_CFG_WR = 4'b1011;

  // Byte merge with active-low lane enables
  function automatic logic [BUS_W-1:0] merge_bytes(input logic [BUS_W-1:0] old_w,
                                                   input logic [BUS_W-1:0] new_w,
                                                   input logic [LANES-1:0] be_n);
    logic [BUS_W-1:0] res;
    for (int b = 0; b < LANES; b++) begin
      res[8*b +: 8] = be_n[b] ? old_w[8*b +: 8] : new_w[8*b +: 8];
    end
    return res;
  endfunction

endpackage

// File: rtl/busreg_decode.sv
module busreg_decode
  import busreg_pkg::*;
#(
  parameter logic [31:0] MEM_BASE  = 32'h4000_0000,
  parameter logic [31:0] IO_BASE   = 32'h0000_1000,
  parameter int          MEM_WORDS = 16,
  parameter int          IO_WORDS  = 4,
  parameter int          CFG_WORDS = 8,
  parameter int          IDX_W     = 4
) (
  input  logic [BUS_W-1:0] ad,
  input  logic [3:0]       cbe_n,
  input  logic             idsel,
  output logic             claim,
  output logic             is_rd,
  output space_e           space,
  output logic [IDX_W-1:0] widx
);

  localparam int MEM_LSB = $clog2(MEM_WORDS) + 2;
  localparam int IO_LSB  = $clog2(IO_WORDS) + 2;
  localparam int CFG_TOP = $clog2(CFG_WORDS) + 2;

  always_comb begin
    claim = 1'b0;
    is_rd = ~cbe_n[0];
    space = SP_MEM;
    widx  = '0;
    case (cbe_n)
      CMD_MEM_RD, CMD_MEM_WR: begin
        space = SP_MEM;
        claim = (ad[31:MEM_LSB] == MEM_BASE[31:MEM_LSB]);
        widx  = IDX_W'(ad[MEM_LSB-1:2]);
      end
      CMD_IO_RD, CMD_IO_WR: begin
        space = SP_IO;
        claim = (ad[31:IO_LSB] == IO_BASE[31:IO_LSB]);
        widx  = IDX_W'(ad[IO_LSB-1:2]);
      end
      CMD_CFG_RD, CMD_CFG_WR: begin
        space = SP_CFG;
        claim = idsel && (ad[1:0] == 2'b00) && (ad[7:CFG_TOP] == '0);
        widx  = IDX_W'(ad[CFG_TOP-1:2]);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/busreg_ctrl.sv
module busreg_ctrl
  import busreg_pkg::*;
#(
  parameter int MEM_WORDS = 16,
  parameter int IO_WORDS  = 4,
  parameter int CFG_WORDS = 8,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_n,
  input  logic             irdy_n,
  input  logic             dec_claim,
  input  logic             dec_rd,
  input  space_e           dec_space,
  input  logic [IDX_W-1:0] dec_widx,
  output logic             devsel_n,
  output logic             trdy_n,
  output logic             ad_oe,
  output logic             wr_en,
  output space_e           cur_space,
  output logic [IDX_W-1:0] cur_widx
);

  tstate_e          st_q, st_d;
  logic             rd_q;
  space_e           sp_q;
  logic [IDX_W-1:0] ix_q, ix_d;
  logic [IDX_W-1:0] wrap_mask;
  logic             addr_phase, ctx_en, xfer, ix_en;

  assign addr_phase = (st_q == ST_IDLE) && !frame_n;
  assign ctx_en     = addr_phase && dec_claim;
  assign xfer       = (st_q == ST_DATA) && !irdy_n;
  assign ix_en      = ctx_en || xfer;

  always_comb begin
    case (sp_q)
      SP_MEM:  wrap_mask = IDX_W'(MEM_WORDS - 1);
      SP_IO:   wrap_mask = IDX_W'(IO_WORDS - 1);
      default: wrap_mask = IDX_W'(CFG_WORDS - 1);
    endcase
  end

  always_comb begin
    ix_d = ctx_en ? dec_widx : ((ix_q + 1'b1) & wrap_mask);
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: begin
        if (addr_phase) begin
          if (dec_claim) st_d = dec_rd ? ST_TURN : ST_DATA;
          else           st_d = ST_SKIP;
        end
      end
      ST_TURN: st_d = ST_DATA;
      ST_DATA: if (xfer && frame_n) st_d = ST_IDLE;
      ST_SKIP: if (frame_n && irdy_n) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      rd_q <= 1'b0;
      sp_q <= SP_MEM;
      ix_q <= '0;
    end else begin
      st_q <= st_d;
      if (ctx_en) begin
        rd_q <= dec_rd;
        sp_q <= dec_space;
      end
      if (ix_en) ix_q <= ix_d;
    end
  end

  assign devsel_n  = !((st_q == ST_TURN) || (st_q == ST_DATA));
  assign trdy_n    = (st_q != ST_DATA);
  assign ad_oe     = (st_q == ST_DATA) && rd_q;
  assign wr_en     = xfer && !rd_q;
  assign cur_space = sp_q;
  assign cur_widx  = ix_q;

  // R10: strobes released after the last data cycle
  p_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!irdy_n && !trdy_n && frame_n) |=> (devsel_n && trdy_n && !ad_oe));

  // R5: data lines are driven only after a cycle of claim without data
  p_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> $past(!devsel_n));

  // R2: a missed decode never raises the claim
  p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && !dec_claim) |=> devsel_n);

  // R7: an initiator wait keeps the word address and the ready strobe
  p_wait_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!trdy_n && irdy_n) |=> ($stable(cur_widx) && !trdy_n));

endmodule

// File: rtl/busreg_bank.sv
module busreg_bank
  import busreg_pkg::*;
#(
  parameter int          MEM_WORDS = 16,
  parameter int          IO_WORDS  = 4,
  parameter int          CFG_WORDS = 8,
  parameter int          IDX_W     = 4,
  parameter logic [31:0] DEV_ID    = 32'h5A17_0C3E
) (
  input  logic             clk,
  input  logic             rst_n,
  input  space_e           space,
  input  logic [IDX_W-1:0] widx,
  input  logic             wr_en,
  input  logic [LANES-1:0] be_n,
  input  logic [BUS_W-1:0] wdata,
  output logic [BUS_W-1:0] rdata
);

  localparam int IO_OFF  = MEM_WORDS;
  localparam int CFG_OFF = MEM_WORDS + IO_WORDS;
  localparam int TOTAL   = CFG_OFF + CFG_WORDS;
  localparam int FW      = $clog2(TOTAL);

  logic [BUS_W-1:0] word_q [TOTAL];
  logic [FW-1:0]    fidx;
  logic [TOTAL-1:0] wen;

  always_comb begin
    case (space)
      SP_MEM:  fidx = FW'(widx);
      SP_IO:   fidx = FW'(IO_OFF) + FW'(widx);
      default: fidx = FW'(CFG_OFF) + FW'(widx);
    endcase
  end

  // Per-word write enables; the identifier dword never takes a write
  for (genvar g = 0; g < TOTAL; g++) begin : g_wen
    if (g == CFG_OFF) begin : g_ro
      assign wen[g] = 1'b0;
    end else begin : g_rw
      assign wen[g] = wr_en && (fidx == FW'(g));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) word_q[i] <= '0;
    end else begin
      for (int i = 0; i < TOTAL; i++) begin
        if (wen[i]) word_q[i] <= merge_bytes(word_q[i], wdata, be_n);
      end
    end
  end

  assign rdata = (fidx == FW'(CFG_OFF)) ? DEV_ID : word_q[fidx];

endmodule

// File: rtl/busreg_target.sv
module busreg_target
  import busreg_pkg::*;
#(
  parameter logic [31:0] MEM_BASE  = 32'h4000_0000,
  parameter logic [31:0] IO_BASE   = 32'h0000_1000,
  parameter int          MEM_BYTES = 64,
  parameter int          IO_BYTES  = 16,
  parameter int          CFG_WORDS = 8,
  parameter logic [31:0] DEV_ID    = 32'h5A17_0C3E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frame_n,
  input  logic        irdy_n,
  input  logic        idsel,
  input  logic [3:0]  cbe_n,
  input  logic [31:0] ad_in,
  output logic        devsel_n,
  output logic        trdy_n,
  output logic [31:0] ad_out,
  output logic        ad_oe
);

  localparam int MEM_WORDS = MEM_BYTES / 4;
  localparam int IO_WORDS  = IO_BYTES / 4;
  localparam int MAX_A     = (MEM_WORDS > IO_WORDS) ? MEM_WORDS : IO_WORDS;
  localparam int MAX_WORDS = (MAX_A > CFG_WORDS) ? MAX_A : CFG_WORDS;
  localparam int IDX_W     = $clog2(MAX_WORDS);

  logic [1:0]       rst_sync_q;
  logic             core_rst_n;
  logic             dec_claim, dec_rd;
  space_e           dec_space, cur_space;
  logic [IDX_W-1:0] dec_widx, cur_widx;
  logic             wr_en;
  logic [BUS_W-1:0] rdata;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  busreg_decode #(
    .MEM_BASE(MEM_BASE), .IO_BASE(IO_BASE), .MEM_WORDS(MEM_WORDS),
    .IO_WORDS(IO_WORDS), .CFG_WORDS(CFG_WORDS), .IDX_W(IDX_W)
  ) u_decode (
    .ad(ad_in), .cbe_n(cbe_n), .idsel(idsel),
    .claim(dec_claim), .is_rd(dec_rd), .space(dec_space), .widx(dec_widx)
  );

  busreg_ctrl #(
    .MEM_WORDS(MEM_WORDS), .IO_WORDS(IO_WORDS), .CFG_WORDS(CFG_WORDS), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst_n(core_rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .dec_claim(dec_claim), .dec_rd(dec_rd), .dec_space(dec_space), .dec_widx(dec_widx),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .ad_oe(ad_oe), .wr_en(wr_en),
    .cur_space(cur_space), .cur_widx(cur_widx)
  );

  busreg_bank #(
    .MEM_WORDS(MEM_WORDS), .IO_WORDS(IO_WORDS), .CFG_WORDS(CFG_WORDS),
    .IDX_W(IDX_W), .DEV_ID(DEV_ID)
  ) u_bank (
    .clk(clk), .rst_n(core_rst_n), .space(cur_space), .widx(cur_widx),
    .wr_en(wr_en), .be_n(cbe_n), .wdata(ad_in), .rdata(rdata)
  );

  assign ad_out = ad_oe ? rdata : '0;

endmodule

// File: tb/tb_busreg_target.sv
module tb_busreg_target;

  localparam logic [31:0] MEM_BASE = 32'h4000_0000;
  localparam logic [31:0] IO_BASE  = 32'h0000_1000;
  localparam logic [31:0] DEV_ID   = 32'h5A17_0C3E;

  logic clk = 1'b0;
  logic rst_n, frame_n, irdy_n, idsel;
  logic [3:0]  cbe_n;
  logic [31:0] ad_in;
  logic        devsel_n, trdy_n, ad_oe;
  logic [31:0] ad_out;

  always #10 clk = ~clk;

  busreg_target #(.MEM_BASE(MEM_BASE), .IO_BASE(IO_BASE), .DEV_ID(DEV_ID)) dut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
    .cbe_n(cbe_n), .ad_in(ad_in), .devsel_n(devsel_n), .trdy_n(trdy_n),
    .ad_out(ad_out), .ad_oe(ad_oe)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic [31:0] m_mem [16];
  logic [31:0] m_io  [4];
  logic [31:0] m_cfg [8];
  logic [31:0] wbuf  [8];
  logic [3:0]  bebuf [8];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int space_of(input logic [3:0] cmd);
    case (cmd[3:1])
      3'b001:  return 1;
      3'b011:  return 0;
      default: return 2;
    endcase
  endfunction

  function automatic int size_of(input int sp);
    return (sp == 0) ? 16 : (sp == 1) ? 4 : 8;
  endfunction

  function automatic logic [31:0] model_rd(input int sp, input int ix);
    if (sp == 0) return m_mem[ix];
    if (sp == 1) return m_io[ix];
    return (ix == 0) ? DEV_ID : m_cfg[ix];
  endfunction

  task automatic model_wr(input int sp, input int ix, input logic [31:0] d, input logic [3:0] be);
    logic [31:0] w;
    w = model_rd(sp, ix);
    for (int b = 0; b < 4; b++) if (!be[b]) w[8*b +: 8] = d[8*b +: 8];
    if (sp == 0) m_mem[ix] = w;
    else if (sp == 1) m_io[ix] = w;
    else if (ix != 0) m_cfg[ix] = w;
  endtask

  task automatic fill_be_all();
    for (int k = 0; k < 8; k++) bebuf[k] = 4'b0000;
  endtask

  // Driver: one claimed transaction of n data cycles, optional single wait at beat wait_at
  task automatic run_xfer(input logic [3:0] cmd, input logic [31:0] addr, input bit sel,
                          input int n, input int wait_at, input string tag);
    bit rd, first, stall, stalled;
    int sp, ix, i;
    rd = !cmd[0];
    sp = space_of(cmd);
    ix = (sp == 0) ? int'(addr[5:2]) : (sp == 1) ? int'(addr[3:2]) : int'(addr[4:2]);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; idsel = sel; ad_in = addr; cbe_n = cmd;
    first = 1'b1; stalled = 1'b0; i = 0;
    while (i < n) begin
      @(negedge clk);
      idsel = 1'b0;
      if (first) begin
        if (rd) chk({tag, " R5 turnaround strobes"}, {29'd0, devsel_n, trdy_n, ad_oe}, 32'd2);
        else    chk({tag, " R6 write ready strobes"}, {29'd0, devsel_n, trdy_n, ad_oe}, 32'd0);
        first = 1'b0;
      end
      stall = (i == wait_at) && !stalled;
      if (stall) stalled = 1'b1;
      irdy_n  = stall;
      cbe_n   = rd ? 4'b0000 : bebuf[i];
      ad_in   = rd ? 32'h0 : wbuf[i];
      frame_n = (i == n - 1) && !stall;
      if (!stall && !trdy_n) begin
        if (rd) begin
          exp_q.push_back(model_rd(sp, ix));
          tag_q.push_back(tag);
        end else begin
          model_wr(sp, ix, wbuf[i], bebuf[i]);
        end
        ix = (ix + 1) % size_of(sp);
        i++;
      end
    end
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b1; cbe_n = 4'b0000; ad_in = 32'h0;
    chk({tag, " R10 release after last"}, {29'd0, devsel_n, trdy_n, ad_oe}, 32'd6);
  endtask

  // Transaction the target must not claim; the initiator gives up after four cycles
  task automatic run_ignored(input logic [3:0] cmd, input logic [31:0] addr, input bit sel,
                             input logic [31:0] data, input string tag);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; idsel = sel; ad_in = addr; cbe_n = cmd;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      idsel = 1'b0; frame_n = 1'b1; irdy_n = 1'b0; ad_in = data; cbe_n = 4'b0000;
      chk({tag, " R12 no claim"}, {30'd0, devsel_n, trdy_n}, 32'd3);
    end
    @(negedge clk);
    irdy_n = 1'b1; ad_in = 32'h0;
    chk({tag, " R12 quiet at idle"}, {30'd0, devsel_n, trdy_n}, 32'd3);
  endtask

  // Monitor: compares read data on each edge that will move a word
  initial begin
    forever begin
      @(posedge clk);
      #17;
      if (rst_n && !irdy_n && !trdy_n && ad_oe) begin
        if (exp_q.size() == 0) begin
          chk("R5 unexpected read beat", ad_out, 32'hDEAD_BEEF);
        end else begin
          automatic logic [31:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(t, ad_out, e);
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; idsel = 1'b0; cbe_n = 4'b0000; ad_in = 32'h0;
    for (int k = 0; k < 16; k++) m_mem[k] = 32'h0;
    for (int k = 0; k < 4; k++)  m_io[k]  = 32'h0;
    for (int k = 0; k < 8; k++)  m_cfg[k] = 32'h0;
    repeat (3) @(negedge clk);
    chk("R1 strobes in reset", {29'd0, devsel_n, trdy_n, ad_oe}, 32'd6);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 strobes after reset", {29'd0, devsel_n, trdy_n, ad_oe}, 32'd6);

    run_xfer(4'b0110, MEM_BASE, 1'b0, 2, -1, "R1 mem zero after reset");
    run_xfer(4'b1010, 32'h0000_0000, 1'b1, 1, -1, "R11 id read");
    fill_be_all(); wbuf[0] = 32'h0;
    run_xfer(4'b1011, 32'h0000_0000, 1'b1, 1, -1, "R11 id write");
    run_xfer(4'b1010, 32'h0000_0000, 1'b1, 1, -1, "R11 id after write");

    fill_be_all(); wbuf[0] = 32'h1122_3344;
    run_xfer(4'b0111, MEM_BASE + 32'h8, 1'b0, 1, -1, "R6 mem single write");
    run_xfer(4'b0110, MEM_BASE + 32'h8, 1'b0, 1, -1, "R3 mem single read");

    fill_be_all();
    wbuf[0] = 32'hA000_0000; wbuf[1] = 32'hA111_1111; wbuf[2] = 32'hA222_2222; wbuf[3] = 32'hA333_3333;
    run_xfer(4'b0111, MEM_BASE + 32'h38, 1'b0, 4, -1, "R8 mem burst write wrap");
    run_xfer(4'b0110, MEM_BASE + 32'h38, 1'b0, 4, 1, "R7 R8 mem burst read with wait");

    bebuf[0] = 4'b1010; wbuf[0] = 32'hFFFF_FFFF;
    run_xfer(4'b0111, MEM_BASE + 32'h8, 1'b0, 1, -1, "R9 partial write");
    run_xfer(4'b0110, MEM_BASE + 32'h8, 1'b0, 1, -1, "R9 partial readback");
    chk("R9 model partial merge", m_mem[2], 32'h11FF_33FF);
    bebuf[0] = 4'b1111; wbuf[0] = 32'hFFFF_FFFF;
    run_xfer(4'b0111, MEM_BASE + 32'hC, 1'b0, 1, -1, "R9 empty mask write");
    run_xfer(4'b0110, MEM_BASE + 32'hC, 1'b0, 1, -1, "R9 empty mask readback");

    fill_be_all(); wbuf[0] = 32'h0101_0303; wbuf[1] = 32'h0202_0000;
    run_xfer(4'b0011, IO_BASE + 32'hC, 1'b0, 2, -1, "R8 io burst write wrap");
    run_xfer(4'b0010, IO_BASE, 1'b0, 4, 2, "R3 R7 io burst read");

    fill_be_all(); wbuf[0] = 32'hC5C5_0005; wbuf[1] = 32'hC6C6_0006;
    run_xfer(4'b1011, 32'h0000_0014, 1'b1, 2, -1, "R4 cfg burst write");
    run_xfer(4'b1010, 32'h0000_0014, 1'b1, 2, -1, "R4 cfg burst read");

    run_ignored(4'b1011, 32'h0000_0014, 1'b0, 32'hBAD0_0001, "R4 cfg without idsel");
    run_ignored(4'b1011, 32'h0000_0034, 1'b1, 32'hBAD0_0002, "R4 cfg high register bits");
    run_ignored(4'b1011, 32'h0000_0015, 1'b1, 32'hBAD0_0003, "R4 cfg low bits set");
    run_xfer(4'b1010, 32'h0000_0014, 1'b1, 1, -1, "R4 cfg unchanged after misses");

    run_ignored(4'b0101, MEM_BASE, 1'b0, 32'hBAD0_0004, "R2 unknown command");
    run_ignored(4'b0111, MEM_BASE + 32'h40, 1'b0, 32'hBAD0_0005, "R3 mem outside window");
    run_ignored(4'b0011, MEM_BASE, 1'b0, 32'hBAD0_0006, "R3 io at mem address");
    run_xfer(4'b0110, MEM_BASE, 1'b0, 1, -1, "R2 R12 mem unchanged after misses");

    repeat (3) @(negedge clk);
    chk("R10 scoreboard drained", exp_q.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule